// File: doc/BRIEF.md
# Nibble-Command Register Access Decoder

This block sits behind a host byte channel and turns a stream of one-byte commands into accesses to a 256-entry register space. Each command byte has two parts. Bits [7:4] hold an opcode and bits [3:0] hold a 4-bit operand. Because each operand is only four bits wide, an 8-bit register address is built from two commands, one for each nibble. An 8-bit write value is also built from two commands. The write takes place on the command that supplies the upper data nibble.

A read command returns one byte on a separate response channel. The same command can step the address up or down afterwards, so a run of registers can be read without reloading the address. Writes and reads at one address reach different registers:

- Addresses 0 to 15 have write-side control registers. These drive the `ctrl_regs` output.
- The read side of addresses 0 to 15 returns a fixed identification pattern.
- Addresses 16 to 255 are general storage. A read there returns the value last written.

Commands for a sample memory are recognised and reported on a side output, but they are not executed here.

Top module: `nibcmd_regport`

## Requirements
- R1: After reset the address, the latched low data nibble and every register are zero. `rsp_valid` and `mem_evt_valid` are low, `cmd_ready` is high and `ctrl_regs` is all zero.
- R2: Opcode 0x0 loads the operand into address bits [3:0]. Opcode 0x1 loads it into address bits [7:4]. The other address nibble is left unchanged.
- R3: Opcode 0x2 latches the operand as the low data nibble. Opcode 0x3 writes {operand, low nibble} to the write register at the current address. For addresses 0 to 15, the value appears on `ctrl_regs[8*a+7:8*a]` in the cycle after the command is accepted.
- R4: Opcode 0x4 raises `rsp_valid` in the cycle after it is accepted, with the read value on `rsp_data`. Both stay unchanged until a cycle in which `rsp_ready` is high.
- R5: A read at an address from 16 to 255 returns the byte last written there, or zero if none has been written. A read at an address from 0 to 15 returns `ID_SEED + address` (modulo 256), whatever has been written there.
- R6: On a read, operand bits [1:0] set the address change that follows it: 01 adds one, 11 subtracts one, and 00 or 10 leaves the address as it is. The address wraps modulo 256, so 0xFF+1 gives 0x00 and 0x00-1 gives 0xFF.
- R7: While a read byte is waiting on the response channel, `cmd_ready` is low. No command is taken until that byte has been accepted.
- R8: Opcodes 0x5 to 0xB are sample-memory commands.
  - An accepted command pulses `mem_evt_valid` for one cycle, in the cycle after it is accepted.
  - For opcode 0x5, `mem_evt_op` is 0x5 and `mem_evt_bank` is 0.
  - For opcodes 0x6 to 0xB, `mem_evt_op` is the opcode with bit 0 cleared and `mem_evt_bank` is opcode bit 0.
  - These commands leave the address, the data nibble and the registers unchanged.
- R9: Opcodes 0xC to 0xF are accepted and ignored. The address, the low data nibble and the registers stay unchanged, and the block produces neither a response nor a memory event.
- R10: The low data nibble is kept after a commit. A later opcode 0x3 with no new opcode 0x2 reuses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command byte is offered |
| cmd_data | input | 8 | Command byte: opcode [7:4], operand [3:0] |
| cmd_ready | output | 1 | The block takes the command in this cycle |
| rsp_valid | output | 1 | A read byte is waiting |
| rsp_data | output | 8 | Read byte |
| rsp_ready | input | 1 | The host takes the read byte |
| mem_evt_valid | output | 1 | One-cycle pulse for a sample-memory command |
| mem_evt_op | output | 4 | Base sample-memory opcode |
| mem_evt_bank | output | 1 | Memory bank selected by the command |
| ctrl_regs | output | 128 | Write-side registers 0 to 15, register a at bits [8a+7:8a] |

## Verification
The hardest case to reach is a command that arrives while a read byte is still waiting. The host has to hold `rsp_ready` low and keep offering an address command for several cycles. The stimulus does this and then confirms, with a later read, that the address never took the blocked nibble. The address wrap at both ends of the space is the other awkward case. To reach it, the bench writes a marker at 0xFF and then steps across the boundary with increment and decrement reads, so the returned bytes show where the address ended up.

// File: rtl/nibcmd_pkg.sv
package nibcmd_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    typedef enum logic [NIB_W-1:0] {
        OP_ADDR_LO   = 4'h0,
        OP_ADDR_HI   = 4'h1,
        OP_DATA_LO   = 4'h2,
        OP_DATA_PUT  = 4'h3,
        OP_READ      = 4'h4,
        OP_MEM_WAIT  = 4'h5,
        OP_MEM_XFR0  = 4'h6,
        OP_MEM_XFR1  = 4'h7,
        OP_MEM_HEAD0 = 4'h8,
        OP_MEM_HEAD1 = 4'h9,
        OP_MEM_BULK0 = 4'hA,
        OP_MEM_BULK1 = 4'hB,
        OP_RSV_C     = 4'hC,
        OP_RSV_D     = 4'hD,
        OP_RSV_E     = 4'hE,
        OP_RSV_F     = 4'hF
    } opcode_e;

    typedef struct packed {
        logic             ld_alo;
        logic             ld_ahi;
        logic             ld_dlo;
        logic             commit;
        logic             rd;
        logic             adj_en;
        logic             adj_dn;
        logic             mem;
        logic [NIB_W-1:0] mem_op;
        logic             mem_bank;
        logic [NIB_W-1:0] operand;
    } dec_t;

    typedef struct packed {
        logic [BYTE_W-1:0] addr;
        logic [NIB_W-1:0]  dlo;
        logic              rsp_valid;
        logic [BYTE_W-1:0] rsp_data;
        logic              mem_valid;
        logic [NIB_W-1:0]  mem_op;
        logic              mem_bank;
    } state_t;

endpackage

// File: rtl/nibcmd_op_decode.sv
module nibcmd_op_decode
    import nibcmd_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd,
    output dec_t              dec
);
    opcode_e op;

    always_comb begin
        op          = opcode_e'(cmd[BYTE_W-1:NIB_W]);
        dec         = '0;
        dec.operand = cmd[NIB_W-1:0];
        dec.adj_en  = cmd[0];
        dec.adj_dn  = cmd[1];
        unique case (op)
            OP_ADDR_LO:  dec.ld_alo = 1'b1;
            OP_ADDR_HI:  dec.ld_ahi = 1'b1;
            OP_DATA_LO:  dec.ld_dlo = 1'b1;
            OP_DATA_PUT: dec.commit = 1'b1;
            OP_READ:     dec.rd     = 1'b1;
            OP_MEM_WAIT: begin
                dec.mem    = 1'b1;
                dec.mem_op = OP_MEM_WAIT;
            end
            OP_MEM_XFR0, OP_MEM_XFR1, OP_MEM_HEAD0, OP_MEM_HEAD1,
            OP_MEM_BULK0, OP_MEM_BULK1: begin
                dec.mem      = 1'b1;
                dec.mem_op   = {op[NIB_W-1:1], 1'b0};
                dec.mem_bank = op[0];
            end
            default: ;
        endcase
        if (!dec.rd) begin
            dec.adj_en = 1'b0;
            dec.adj_dn = 1'b0;
        end
    end
endmodule

// File: rtl/nibcmd_regbank.sv
module nibcmd_regbank
    import nibcmd_pkg::*;
#(
    parameter int                FUNC_REGS = 16,
    parameter logic [BYTE_W-1:0] ID_SEED   = 8'hC0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [BYTE_W-1:0]             wr_addr,
    input  logic [BYTE_W-1:0]             wr_data,
    input  logic [BYTE_W-1:0]             rd_addr,
    output logic [BYTE_W-1:0]             rd_data,
    output logic [FUNC_REGS*BYTE_W-1:0]   ctrl_flat
);
    localparam int                DEPTH    = 1 << BYTE_W;
    localparam int                GP_DEPTH = DEPTH - FUNC_REGS;
    localparam logic [BYTE_W-1:0] FUNC_LIM = BYTE_W'(FUNC_REGS);

    logic [BYTE_W-1:0] gp_q [GP_DEPTH];
    logic [BYTE_W-1:0] gp_wr_idx;
    logic [BYTE_W-1:0] gp_rd_idx;

    assign gp_wr_idx = wr_addr - FUNC_LIM;
    assign gp_rd_idx = rd_addr - FUNC_LIM;

    genvar i;
    generate
        for (i = 0; i < FUNC_REGS; i++) begin : g_ctrl
            logic [BYTE_W-1:0] ctrl_d, ctrl_q;

            always_comb begin
                ctrl_d = ctrl_q;
                if (wr_en && wr_addr == BYTE_W'(i)) ctrl_d = wr_data;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) ctrl_q <= '0;
                else        ctrl_q <= ctrl_d;
            end

            assign ctrl_flat[i*BYTE_W +: BYTE_W] = ctrl_q;

            assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr == BYTE_W'(i)) |=> (ctrl_q == $past(wr_data)));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < GP_DEPTH; k++) gp_q[k] <= '0;
        end else if (wr_en && wr_addr >= FUNC_LIM) begin
            gp_q[gp_wr_idx] <= wr_data;
        end
    end

    always_comb begin
        if (rd_addr < FUNC_LIM) rd_data = ID_SEED + rd_addr;
        else                    rd_data = gp_q[gp_rd_idx];
    end
endmodule

// File: rtl/nibcmd_regport.sv
module nibcmd_regport
    import nibcmd_pkg::*;
#(
    parameter int                FUNC_REGS = 16,
    parameter logic [BYTE_W-1:0] ID_SEED   = 8'hC0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  logic [BYTE_W-1:0]           cmd_data,
    output logic                        cmd_ready,
    output logic                        rsp_valid,
    output logic [BYTE_W-1:0]           rsp_data,
    input  logic                        rsp_ready,
    output logic                        mem_evt_valid,
    output logic [NIB_W-1:0]            mem_evt_op,
    output logic                        mem_evt_bank,
    output logic [FUNC_REGS*BYTE_W-1:0] ctrl_regs
);
    state_t            st_d, st_q;
    dec_t              dec;
    logic              fire;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;

    nibcmd_op_decode u_dec (
        .cmd (cmd_data),
        .dec (dec)
    );

    nibcmd_regbank #(
        .FUNC_REGS (FUNC_REGS),
        .ID_SEED   (ID_SEED)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (st_q.addr),
        .wr_data   (wr_data),
        .rd_addr   (st_q.addr),
        .rd_data   (rd_data),
        .ctrl_flat (ctrl_regs)
    );

    assign cmd_ready = !st_q.rsp_valid;
    assign fire      = cmd_valid && cmd_ready;
    assign wr_en     = fire && dec.commit;
    assign wr_data   = {dec.operand, st_q.dlo};

    always_comb begin
        st_d           = st_q;
        st_d.mem_valid = 1'b0;
        if (st_q.rsp_valid && rsp_ready) st_d.rsp_valid = 1'b0;
        if (fire) begin
            if (dec.ld_alo) st_d.addr[NIB_W-1:0]      = dec.operand;
            if (dec.ld_ahi) st_d.addr[BYTE_W-1:NIB_W] = dec.operand;
            if (dec.ld_dlo) st_d.dlo                  = dec.operand;
            if (dec.rd) begin
                st_d.rsp_valid = 1'b1;
                st_d.rsp_data  = rd_data;
                if (dec.adj_en)
                    st_d.addr = dec.adj_dn ? st_q.addr - 1'b1 : st_q.addr + 1'b1;
            end
            if (dec.mem) begin
                st_d.mem_valid = 1'b1;
                st_d.mem_op    = dec.mem_op;
                st_d.mem_bank  = dec.mem_bank;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid     = st_q.rsp_valid;
    assign rsp_data      = st_q.rsp_data;
    assign mem_evt_valid = st_q.mem_valid;
    assign mem_evt_op    = st_q.mem_op;
    assign mem_evt_bank  = st_q.mem_bank;

    assert_rsp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    assert_read_answers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && dec.rd) |=> rsp_valid);

    assert_addr_incr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && dec.rd && cmd_data[1:0] == 2'b01) |=> (st_q.addr == $past(st_q.addr) + 8'd1));

    assert_addr_decr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && dec.rd && cmd_data[1:0] == 2'b11) |=> (st_q.addr == $past(st_q.addr) - 8'd1));

    assert_blocked_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> ($stable(st_q.addr) && $stable(st_q.dlo)));

    assert_mem_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_data[7:4] >= 4'h5 && cmd_data[7:4] <= 4'hB) |=> (mem_evt_valid && $stable(st_q.addr)));

    assert_unknown_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_data[7:4] >= 4'hC) |=> ($stable(st_q.addr) && $stable(st_q.dlo) && !mem_evt_valid));
endmodule

// File: tb/nibcmd_regport_test.sv
module nibcmd_regport_test;
    localparam logic [7:0] SEED = 8'hC0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [7:0]   cmd_data = '0;
    logic         cmd_ready;
    logic         rsp_valid;
    logic [7:0]   rsp_data;
    logic         rsp_ready = 1'b0;
    logic         mem_evt_valid;
    logic [3:0]   mem_evt_op;
    logic         mem_evt_bank;
    logic [127:0] ctrl_regs;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    nibcmd_regport #(.FUNC_REGS(16), .ID_SEED(SEED)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_ready(rsp_ready), .mem_evt_valid(mem_evt_valid), .mem_evt_op(mem_evt_op),
        .mem_evt_bank(mem_evt_bank), .ctrl_regs(ctrl_regs)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [3:0] op, input logic [3:0] arg);
        cmd_valid = 1'b1;
        cmd_data  = {op, arg};
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic set_addr(input logic [7:0] a);
        put(4'h0, a[3:0]);
        put(4'h1, a[7:4]);
    endtask

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        set_addr(a);
        put(4'h2, d[3:0]);
        put(4'h3, d[7:4]);
    endtask

    task automatic rd_expect(input logic [3:0] adj, input logic [7:0] exp, input string tag);
        put(4'h4, adj);
        chk({tag, " rsp_valid"}, rsp_valid, 1);
        chk({tag, " rsp_data"}, rsp_data, exp);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk({tag, " rsp drained"}, rsp_valid, 0);
    endtask

    task automatic t_reset;
        chk("R1 cmd_ready", cmd_ready, 1);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 mem_evt_valid", mem_evt_valid, 0);
        chk("R1 ctrl_regs zero", (ctrl_regs == '0), 1);
        rd_expect(4'h0, SEED, "R1 address zero reads id");
        set_addr(8'h10);
        rd_expect(4'h0, 8'h00, "R1 storage cleared");
    endtask

    task automatic t_addr_data;
        wr_byte(8'h5A, 8'h3C);
        wr_byte(8'hA5, 8'hE1);
        set_addr(8'h5A);
        rd_expect(4'h0, 8'h3C, "R2 R5 read 0x5A");
        put(4'h1, 4'hA);
        put(4'h0, 4'h5);
        rd_expect(4'h0, 8'hE1, "R2 nibble order 0xA5");
        put(4'h0, 4'hA);
        rd_expect(4'h0, 8'h00, "R2 low nibble only 0xAA");
    endtask

    task automatic t_func_regs;
        wr_byte(8'h0A, 8'h96);
        chk("R3 ctrl reg 10", ctrl_regs[10*8 +: 8], 8'h96);
        wr_byte(8'h00, 8'h71);
        chk("R3 ctrl reg 0", ctrl_regs[7:0], 8'h71);
        set_addr(8'h0A);
        rd_expect(4'h0, SEED + 8'h0A, "R5 id view separate from write view");
    endtask

    task automatic t_autoadjust;
        wr_byte(8'hFF, 8'hAB);
        wr_byte(8'h20, 8'h11);
        wr_byte(8'h21, 8'h22);
        set_addr(8'h20);
        rd_expect(4'h1, 8'h11, "R6 inc first");
        rd_expect(4'h0, 8'h22, "R6 incremented");
        rd_expect(4'h2, 8'h22, "R6 code 10 holds");
        rd_expect(4'h3, 8'h22, "R6 dec read");
        rd_expect(4'h0, 8'h11, "R6 decremented");
        set_addr(8'hFF);
        rd_expect(4'h1, 8'hAB, "R6 at 0xFF");
        rd_expect(4'h3, SEED, "R6 wrapped up to 0x00");
        rd_expect(4'h0, 8'hAB, "R6 wrapped down to 0xFF");
    endtask

    task automatic t_backpressure;
        wr_byte(8'h40, 8'h3C);
        set_addr(8'h40);
        put(4'h4, 4'h0);
        cmd_valid = 1'b1;
        cmd_data  = 8'h0F;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R7 cmd_ready low", cmd_ready, 0);
            chk("R4 rsp held", rsp_valid, 1);
            chk("R4 data held", rsp_data, 8'h3C);
        end
        cmd_valid = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R7 ready after drain", cmd_ready, 1);
        rd_expect(4'h0, 8'h3C, "R7 blocked command not taken");
    endtask

    task automatic t_mem;
        set_addr(8'h30);
        put(4'h2, 4'h9);
        for (int op = 5; op <= 11; op++) begin
            logic [3:0] o;
            o = 4'(op);
            put(o, 4'h3);
            chk("R8 event valid", mem_evt_valid, 1);
            chk("R8 event op", mem_evt_op, (o == 4'h5) ? 4'h5 : {o[3:1], 1'b0});
            chk("R8 event bank", mem_evt_bank, (o == 4'h5) ? 1'b0 : o[0]);
            chk("R8 no response", rsp_valid, 0);
            @(negedge clk);
            chk("R8 single pulse", mem_evt_valid, 0);
        end
        put(4'h3, 4'h4);
        set_addr(8'h30);
        rd_expect(4'h0, 8'h49, "R8 address and nibble kept");
    endtask

    task automatic t_unknown;
        set_addr(8'h25);
        put(4'h2, 4'h7);
        for (int op = 12; op <= 15; op++) begin
            put(4'(op), 4'(op));
            chk("R9 no response", rsp_valid, 0);
            chk("R9 no event", mem_evt_valid, 0);
            chk("R9 still ready", cmd_ready, 1);
        end
        put(4'h3, 4'h1);
        rd_expect(4'h0, 8'h17, "R9 address and nibble unchanged");
    endtask

    task automatic t_dlo_reuse;
        set_addr(8'h50);
        put(4'h2, 4'hD);
        put(4'h3, 4'h2);
        put(4'h0, 4'h1);
        put(4'h3, 4'h6);
        set_addr(8'h50);
        rd_expect(4'h1, 8'h2D, "R10 first commit");
        rd_expect(4'h0, 8'h6D, "R10 nibble reused");
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_addr_data;
        t_func_regs;
        t_autoadjust;
        t_backpressure;
        t_mem;
        t_unknown;
        t_dlo_reuse;
        summary;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary;
    end
endmodule